// File: doc/BRIEF.md
# Stack Operand Fetch and Dispatch Sequencer

This block carries one instruction of a 16-bit stack machine from its decoded fields through to result write-back. Each instruction names its own source for both operands: constant zero, an immediate word, a non-destructive read of the top of stack, or a destructive pop. It also names one destination for the result: drop it, push it, or load it into the instruction pointer as a jump target. Because every instruction chooses these freely, any command can push, drop or branch. A plain pop is simply a copy command with a popping first input and a dropped result.

The sequencer owns the stack pointer and the instruction pointer. It drives a single-port synchronous stack memory, where read data returns one cycle after the request. It presents both operands as registered outputs to an external command unit, which returns its result combinationally. A one-cycle `start_i` launches an instruction. `busy_o` stays high while it runs, and `done_o` pulses once after write-back.

Top module: `stack_exec`

## Requirements
- R1: After reset, `sp_o` equals `SP_INIT` (default 0), `ip_o` equals `IP_INIT` (default 0), and `done_o`, `busy_o` and `mem_en_o` are low.
- R2: An input selector of 2'b00 gives that operand the value 0, and 2'b01 gives it the instruction's immediate word for that input. Neither choice touches the stack pointer.
- R3: An input selector of 2'b10 (peek) gives the operand the word at address `sp_o` and leaves the stack pointer unchanged.
- R4: An input selector of 2'b11 (pop) gives the operand the word at address `sp_o` and then increments the stack pointer by one. The stack pointer never moves by more than one per cycle.
- R5: Input 0 is resolved before input 1. When input 0 pops, a stack-reading input 1 sees the next element down. When both pop, the stack pointer rises by two.
- R6: An output selector of 2'b01 (push) decrements the stack pointer and writes the command result at the new `sp_o` address. A write always asserts `mem_en_o` together with `mem_we_o`.
- R7: An output selector of 2'b10 (jump) loads the command result into `ip_o`. Every other executed or skipped instruction advances `ip_o` by one. `ip_o` changes only in the cycle `done_o` is high.
- R8: An output selector of 2'b00 or the reserved 2'b11 drops the result. There is no memory write, and the stack pointer changes only through the inputs.
- R9: When `exec_en_i` is low at start, no operand is read, the stack pointer and memory are unchanged, and `ip_o` advances by one.
- R10: `done_o` is high for exactly one cycle per instruction, one cycle after write-back. `sp_o` and `ip_o` do not change while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch one instruction (sampled while idle) |
| exec_en_i | input | 1 | Instruction condition passed; low skips it |
| in0_sel_i | input | 2 | Input 0 source: 00 zero, 01 immediate, 10 peek, 11 pop |
| in1_sel_i | input | 2 | Input 1 source, same encoding |
| imm0_i | input | DATA_W | Immediate word for input 0 |
| imm1_i | input | DATA_W | Immediate word for input 1 |
| out_sel_i | input | 2 | Destination: 00 drop, 01 push, 10 jump, 11 drop |
| op0_o | output | DATA_W | Operand 0 to the command unit |
| op1_o | output | DATA_W | Operand 1 to the command unit |
| res_i | input | DATA_W | Combinational result from the command unit |
| mem_en_o | output | 1 | Stack memory access enable |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_addr_o | output | ADDR_W | Stack memory word address |
| mem_wdata_o | output | DATA_W | Stack memory write data |
| mem_rdata_i | input | DATA_W | Stack memory read data, one cycle after request |
| sp_o | output | ADDR_W | Stack pointer |
| ip_o | output | IP_W | Instruction pointer |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The command unit is modelled as `op0 - op1`. Because subtraction is not symmetric, a swap of operand order shows up at once, and with input 1 at zero it becomes a copy. Immediates pushed over an initially empty stack make the pop/pop case distinguishable from peek/peek and from pop followed by peek. The pop/pop case separates a correct double increment from a single one, and the pop-then-peek case checks that input 1 reads below the element input 0 removed. Jump, reserved-output, skipped and pop-only instructions each tell apart which of the stack pointer, instruction pointer and stack contents a destination may move.

// File: rtl/stack_exec_pkg.sv
package stack_exec_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_IMM  = 2'b01,
    SRC_PEEK = 2'b10,
    SRC_POP  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    DST_DROP = 2'b00,
    DST_PUSH = 2'b01,
    DST_JUMP = 2'b10,
    DST_RSVD = 2'b11
  } dst_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_CAP,
    ST_WB,
    ST_DONE
  } state_e;

  localparam int unsigned NUM_SLOTS = 2;
endpackage

// File: rtl/se_operand_slot.sv
module se_operand_slot
  import stack_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  src_e              sel_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] op_o
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (sel_i)
      SRC_ZERO: nxt = '0;
      SRC_IMM:  nxt = imm_i;
      default:  nxt = mem_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     op_o <= '0;
    else if (load_i) op_o <= nxt;
  end
endmodule

// File: rtl/se_sp_unit.sv
module se_sp_unit #(
  parameter int unsigned    ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] sp_dec_o
);
  assign sp_dec_o = sp_o - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_o <= SP_INIT;
    else if (inc_i) sp_o <= sp_o + ADDR_W'(1);
    else if (dec_i) sp_o <= sp_dec_o;
  end
endmodule

// File: rtl/se_ip_unit.sv
module se_ip_unit #(
  parameter int unsigned      IP_W    = 16,
  parameter logic [IP_W-1:0]  IP_INIT = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            jump_i,
  input  logic [IP_W-1:0] target_i,
  output logic [IP_W-1:0] ip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ip_o <= IP_INIT;
    else if (step_i) ip_o <= jump_i ? target_i : ip_o + IP_W'(1);
  end
endmodule

// File: rtl/stack_exec.sv
module stack_exec
  import stack_exec_pkg::*;
#(
  parameter int unsigned         DATA_W  = 16,
  parameter int unsigned         ADDR_W  = 8,
  parameter int unsigned         IP_W    = 16,
  parameter logic [ADDR_W-1:0]   SP_INIT = '0,
  parameter logic [IP_W-1:0]     IP_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              exec_en_i,
  input  logic [1:0]        in0_sel_i,
  input  logic [1:0]        in1_sel_i,
  input  logic [DATA_W-1:0] imm0_i,
  input  logic [DATA_W-1:0] imm1_i,
  input  logic [1:0]        out_sel_i,
  output logic [DATA_W-1:0] op0_o,
  output logic [DATA_W-1:0] op1_o,
  input  logic [DATA_W-1:0] res_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [IP_W-1:0]   ip_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  state_e             state_q, state_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  src_e               sel_q [NUM_SLOTS];
  logic [DATA_W-1:0]  imm_q [NUM_SLOTS];
  logic [DATA_W-1:0]  op    [NUM_SLOTS];
  dst_e               dst_q;
  logic               exec_q;

  src_e               cur_sel;
  logic               cur_stack;
  logic               do_push, sp_inc, sp_dec, ip_step;
  logic [ADDR_W-1:0]  sp_dec_val;

  assign cur_sel   = sel_q[slot_q];
  assign cur_stack = (cur_sel == SRC_PEEK) || (cur_sel == SRC_POP);
  assign do_push   = exec_q && (dst_q == DST_PUSH);

  // latch decoded fields at launch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q[0] <= SRC_ZERO;
      sel_q[1] <= SRC_ZERO;
      imm_q[0] <= '0;
      imm_q[1] <= '0;
      dst_q    <= DST_DROP;
      exec_q   <= 1'b0;
    end else if (state_q == ST_IDLE && start_i) begin
      sel_q[0] <= src_e'(in0_sel_i);
      sel_q[1] <= src_e'(in1_sel_i);
      imm_q[0] <= imm0_i;
      imm_q[1] <= imm1_i;
      dst_q    <= dst_e'(out_sel_i);
      exec_q   <= exec_en_i;
    end
  end

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SRC;
        slot_d  = '0;
      end
      ST_SRC: begin
        if (!exec_q)       state_d = ST_WB;
        else if (cur_stack) state_d = ST_CAP;
        else if (slot_q == LAST_SLOT) state_d = ST_WB;
        else slot_d = slot_q + SLOT_W'(1);
      end
      ST_CAP: begin
        if (slot_q == LAST_SLOT) state_d = ST_WB;
        else begin
          state_d = ST_SRC;
          slot_d  = slot_q + SLOT_W'(1);
        end
      end
      ST_WB:   state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic ld;
    assign ld = (slot_q == SLOT_W'(g)) &&
                ((state_q == ST_SRC && exec_q && !cur_stack) || state_q == ST_CAP);
    se_operand_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ld),
      .sel_i  (sel_q[g]),
      .imm_i  (imm_q[g]),
      .mem_i  (mem_rdata_i),
      .op_o   (op[g])
    );
  end

  assign op0_o = op[0];
  assign op1_o = op[1];

  assign sp_inc  = (state_q == ST_CAP) && (cur_sel == SRC_POP);
  assign sp_dec  = (state_q == ST_WB) && do_push;
  assign ip_step = (state_q == ST_WB);

  se_sp_unit #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (sp_inc),
    .dec_i    (sp_dec),
    .sp_o     (sp_o),
    .sp_dec_o (sp_dec_val)
  );

  se_ip_unit #(.IP_W(IP_W), .IP_INIT(IP_INIT)) u_ip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (ip_step),
    .jump_i   (exec_q && dst_q == DST_JUMP),
    .target_i (IP_W'(res_i)),
    .ip_o     (ip_o)
  );

  assign mem_en_o    = (state_q == ST_SRC && exec_q && cur_stack) || sp_dec;
  assign mem_we_o    = sp_dec;
  assign mem_addr_o  = sp_dec ? sp_dec_val : sp_o;
  assign mem_wdata_o = res_i;

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/stack_exec_chk.sv
module stack_exec_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IP_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic [IP_W-1:0]   ip_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(sp_o) && $stable(ip_o)));

  assert_write_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);

  assert_push_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(mem_addr_o)));

  assert_sp_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> (sp_o == ADDR_W'($past(sp_o) + 1'b1) ||
                        sp_o == ADDR_W'($past(sp_o) - 1'b1)));

  assert_ip_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ip_o) |-> done_o);
endmodule

bind stack_exec stack_exec_chk #(.ADDR_W(ADDR_W), .IP_W(IP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_en_o   (mem_en_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .sp_o       (sp_o),
  .ip_o       (ip_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_stack_exec.sv
module tb_stack_exec;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int IW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          exec_en = 1'b0;
  logic [1:0]    s0 = '0, s1 = '0, os = '0;
  logic [DW-1:0] im0 = '0, im1 = '0;
  logic [DW-1:0] op0, op1, res, wdata, rdata;
  logic          men, mwe, busy, done;
  logic [AW-1:0] maddr, sp;
  logic [IW-1:0] ip;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign res = op0 - op1;

  always @(posedge clk) begin
    if (men) begin
      if (mwe) mem[maddr] <= wdata;
      else     rdata <= mem[maddr];
    end
  end

  stack_exec dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .exec_en_i(exec_en),
    .in0_sel_i(s0), .in1_sel_i(s1), .imm0_i(im0), .imm1_i(im1),
    .out_sel_i(os), .op0_o(op0), .op1_o(op1), .res_i(res),
    .mem_en_o(men), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .sp_o(sp), .ip_o(ip), .busy_o(busy), .done_o(done)
  );

  typedef struct {
    string         tag;
    logic [AW-1:0] sp;
    logic [IW-1:0] ip;
    logic          chk_ops;
    logic [DW-1:0] op0;
    logic [DW-1:0] op1;
  } exp_t;

  exp_t sb[$];

  logic [AW-1:0] m_sp = '0;
  logic [IW-1:0] m_ip = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] fetch(input logic [1:0] sel, input logic [DW-1:0] imm);
    logic [DW-1:0] v;
    case (sel)
      2'b00: v = '0;
      2'b01: v = imm;
      2'b10: v = exp_mem[m_sp];
      default: begin
        v = exp_mem[m_sp];
        m_sp = m_sp + 1'b1;
      end
    endcase
    return v;
  endfunction

  // driver: model the instruction, queue the expectation, run it
  task automatic instr(input string tag, input logic en, input logic [1:0] a,
                       input logic [DW-1:0] ia, input logic [1:0] b,
                       input logic [DW-1:0] ib, input logic [1:0] o);
    exp_t e;
    logic [DW-1:0] v0, v1, r;
    v0 = '0; v1 = '0;
    if (en) begin
      v0 = fetch(a, ia);
      v1 = fetch(b, ib);
      r  = v0 - v1;
      if (o == 2'b01) begin
        m_sp = m_sp - 1'b1;
        exp_mem[m_sp] = r;
      end
      if (o == 2'b10) m_ip = IW'(r);
      else            m_ip = m_ip + 1'b1;
    end else begin
      m_ip = m_ip + 1'b1;
    end
    e.tag = tag; e.sp = m_sp; e.ip = m_ip; e.chk_ops = en; e.op0 = v0; e.op1 = v1;
    sb.push_back(e);
    @(negedge clk);
    exec_en = en; s0 = a; s1 = b; im0 = ia; im1 = ib; os = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check({tag, " done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  // monitor: compare at each completion pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb.size() == 0) begin
          check("R10 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " sp"}, 32'(sp), 32'(e.sp));
          check({e.tag, " ip"}, 32'(ip), 32'(e.ip));
          check({e.tag, " top"}, 32'(mem[sp]), 32'(exp_mem[e.sp]));
          if (e.chk_ops) begin
            check({e.tag, " op0"}, 32'(op0), 32'(e.op0));
            check({e.tag, " op1"}, 32'(op1), 32'(e.op1));
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 1000000; i++) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '0;
      exp_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 sp", 32'(sp), 32'd0);
    check("R1 ip", 32'(ip), 32'd0);
    check("R1 done/busy/men", {29'd0, done, busy, men}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {30'd0, busy, done}, 32'd0);

    instr("R2 R6 push imm",     1'b1, 2'b01, 16'h1234, 2'b00, 16'h0000, 2'b01);
    instr("R2 R6 push imm-imm", 1'b1, 2'b01, 16'h0005, 2'b01, 16'h0002, 2'b01);
    instr("R3 peek peek drop",  1'b1, 2'b10, 16'h0000, 2'b10, 16'h0000, 2'b00);
    instr("R4 R8 copy pop",     1'b1, 2'b11, 16'h0000, 2'b00, 16'h0000, 2'b00);
    instr("R6 push ten",        1'b1, 2'b01, 16'h000A, 2'b00, 16'h0000, 2'b01);
    instr("R6 push four",       1'b1, 2'b01, 16'h0004, 2'b00, 16'h0000, 2'b01);
    instr("R5 pop pop push",    1'b1, 2'b11, 16'h0000, 2'b11, 16'h0000, 2'b01);
    instr("R7 jump imm",        1'b1, 2'b01, 16'h0040, 2'b00, 16'h0000, 2'b10);
    instr("R9 skipped pop push",1'b0, 2'b11, 16'h0000, 2'b11, 16'h0000, 2'b01);
    instr("R8 reserved out",    1'b1, 2'b10, 16'h0000, 2'b01, 16'h0001, 2'b11);
    instr("R6 push seven",      1'b1, 2'b01, 16'h0007, 2'b00, 16'h0000, 2'b01);
    instr("R5 R7 pop peek jump",1'b1, 2'b11, 16'h0000, 2'b10, 16'h0000, 2'b10);
    instr("R9 skipped jump",    1'b0, 2'b01, 16'h0100, 2'b00, 16'h0000, 2'b10);

    repeat (4) @(negedge clk);
    check("R10 queue drained", 32'(sb.size()), 32'd0);
    check("R10 idle at end", {31'd0, busy}, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule